// File: doc/BRIEF.md
# Byte Read-Modify-Write Adapter

This block sits between a CPU-side port that issues single-byte reads and writes and a memory that can only be read or written as a whole 64-bit word. The memory has no byte-lane enables. A byte write therefore runs in three phases. The adapter reads the containing word into a holding register. It overwrites one lane of that word with the new byte. It then writes the whole word back. A byte read also fetches the full word, and the adapter returns only the addressed lane. A full aligned word write skips the read phase and goes to memory directly.

The adapter handles one request at a time. It takes a request only while it signals ready, and it finishes every request with a one-cycle response pulse. Memory read data is expected one cycle after the read strobe.

Top module: `byte_rmw_adapter`

## Requirements
- R1: Out of reset, and whenever no request is in progress, `req_ready_o` is 1, both memory strobes are 0 and `rsp_valid_o` is 0. `req_ready_o` is 0 from the cycle after acceptance until the response cycle, inclusive.
- R2: The memory is only accessed as whole words. The read and write strobes are never high together. `mem_addr_o` equals the byte address with its low three bits removed, so consecutive words differ by 1.
- R3: A byte write raises `mem_rd_o` in the cycle after acceptance. It raises `mem_wr_o` two cycles after the read strobe. It raises `rsp_valid_o` in the cycle after the write strobe.
- R4: The word written back for a byte write equals the word read, except in the addressed lane. That lane holds the new byte. The response byte of a byte write is the byte written.
- R5: Lanes are little-endian. Byte offset k (address bits 2:0) selects word bits 8k+7 down to 8k.
- R6: A byte read raises `mem_rd_o` in the cycle after acceptance and never raises `mem_wr_o`. Two cycles after the read strobe it raises `rsp_valid_o`, with the addressed lane on `rsp_byte_o`.
- R7: A full word write (`req_write_i` and `req_full_i` both 1) does no memory read. It raises `mem_wr_o` with `req_word_i` in the cycle after acceptance, and the response follows one cycle later. The low three address bits are ignored. The response byte is word bits 7:0.
- R8: `rsp_valid_o` is high for exactly one cycle. `req_ready_o` returns in the next cycle, so a new request can be accepted there with no gap.
- R9: A request presented while `req_ready_o` is 0 is ignored. It causes no memory access and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Adapter idle, request taken when valid |
| req_write_i | input | 1 | 1 write, 0 byte read |
| req_full_i | input | 1 | With write: whole aligned word write |
| req_addr_i | input | ADDR_W | Byte address |
| req_byte_i | input | 8 | Byte to write |
| req_word_i | input | 64 | Word for full writes |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_byte_o | output | 8 | Selected lane of the final word |
| mem_rd_o | output | 1 | Word read strobe |
| mem_wr_o | output | 1 | Word write strobe |
| mem_addr_o | output | ADDR_W-3 | Word address |
| mem_wdata_o | output | 64 | Word to write |
| mem_rdata_i | input | 64 | Read word, valid one cycle after `mem_rd_o` |

## Verification
The bench builds the adapter with an 8-bit byte address, which gives a 32-word memory. Random traffic therefore keeps landing on the same few words. Successive read-modify-writes stack on earlier merges, and every one of the eight lanes is hit in both directions. The bench also holds a junk full-word request high through busy periods and issues requests back to back, which covers the ignore rule and the zero-gap return to ready.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MERGE = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } rmw_state_e;
endpackage

// File: rtl/rmw_seq_ctrl.sv
module rmw_seq_ctrl
  import rmw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       start_full_i,
  input  logic       op_write_i,
  output rmw_state_e state_o,
  output logic       ready_o
);
  rmw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = start_full_i ? ST_WRITE : ST_READ;
      ST_READ:  state_d = ST_MERGE;
      ST_MERGE: state_d = op_write_i ? ST_WRITE : ST_DONE;
      ST_WRITE: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign ready_o = (state_q == ST_IDLE);

  // read data is consumed exactly one cycle after the read phase
  assert_read_then_merge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_READ |=> state_q == ST_MERGE);

  assert_done_then_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE |=> state_q == ST_IDLE);
endmodule

// File: rtl/rmw_lane_merge.sv
module rmw_lane_merge #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int W = LANES * 8
) (
  input  logic [W-1:0]     word_i,
  input  logic [7:0]       byte_i,
  input  logic [OFF_W-1:0] lane_i,
  output logic [W-1:0]     word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_o[g*8 +: 8] = (lane_i == OFF_W'(g)) ? byte_i : word_i[g*8 +: 8];
  end
endmodule

// File: rtl/rmw_lane_pick.sv
module rmw_lane_pick #(
  parameter int LANES = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int W = LANES * 8
) (
  input  logic [W-1:0]     word_i,
  input  logic [OFF_W-1:0] lane_i,
  output logic [7:0]       byte_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[g*8 +: 8];
  end

  assign byte_o = lanes[lane_i];
endmodule

// File: rtl/byte_rmw_adapter.sv
module byte_rmw_adapter
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WADDR_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic               req_full_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [7:0]         req_byte_i,
  input  logic [DATA_W-1:0]  req_word_i,
  output logic               rsp_valid_o,
  output logic [7:0]         rsp_byte_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic [WADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);
  rmw_state_e         state;
  logic               accept, full_req;
  logic [WADDR_W-1:0] waddr_q;
  logic [OFF_W-1:0]   lane_q;
  logic               wr_q, full_q;
  logic [7:0]         byte_q;
  logic [DATA_W-1:0]  hold_q, merged;

  assign full_req = req_write_i & req_full_i;
  assign accept   = req_valid_i & req_ready_o;

  rmw_seq_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (accept),
    .start_full_i (full_req),
    .op_write_i   (wr_q),
    .state_o      (state),
    .ready_o      (req_ready_o)
  );

  rmw_lane_merge #(.LANES(LANES)) u_merge (
    .word_i (mem_rdata_i),
    .byte_i (byte_q),
    .lane_i (lane_q),
    .word_o (merged)
  );

  rmw_lane_pick #(.LANES(LANES)) u_pick (
    .word_i (hold_q),
    .lane_i (lane_q),
    .byte_o (rsp_byte_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_q <= '0;
      lane_q  <= '0;
      wr_q    <= 1'b0;
      full_q  <= 1'b0;
      byte_q  <= '0;
      hold_q  <= '0;
    end else if (accept) begin
      waddr_q <= req_addr_i[ADDR_W-1:OFF_W];
      lane_q  <= full_req ? '0 : req_addr_i[OFF_W-1:0];
      wr_q    <= req_write_i;
      full_q  <= full_req;
      byte_q  <= req_byte_i;
      if (full_req) hold_q <= req_word_i;
    end else if (state == ST_MERGE) begin
      // read data arrives one cycle after the strobe
      hold_q <= wr_q ? merged : mem_rdata_i;
    end
  end

  assign mem_rd_o    = (state == ST_READ);
  assign mem_wr_o    = (state == ST_WRITE);
  assign mem_addr_o  = waddr_q;
  assign mem_wdata_o = hold_q;
  assign rsp_valid_o = (state == ST_DONE);

  logic [DATA_W-1:0] lane_mask;
  assign lane_mask = {{(DATA_W-8){1'b0}}, 8'hFF} << {lane_q, 3'b000};

  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o || rsp_valid_o) |-> !req_ready_o);

  assert_rd_wr_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_writeback_after_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !full_q) |-> $past(mem_rd_o, 2));

  assert_other_lanes_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !full_q) |-> (((mem_wdata_o ^ $past(mem_rdata_i)) & ~lane_mask) == '0));

  assert_new_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !full_q) |-> ((mem_wdata_o & lane_mask) == ({{(DATA_W-8){1'b0}}, byte_q} << {lane_q, 3'b000})));

  assert_read_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !wr_q) |-> ($past(mem_rd_o, 2) && !$past(mem_wr_o)));

  assert_full_skips_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && full_q) |-> !$past(mem_rd_o));

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (req_ready_o && !rsp_valid_o));

  assert_no_access_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_rd_o && !mem_wr_o && !rsp_valid_o));
endmodule

// File: tb/byte_rmw_adapter_bench.sv
module byte_rmw_adapter_bench;
  localparam int AW  = 8;
  localparam int DW  = 64;
  localparam int WAW = AW - 3;
  localparam int NW  = 1 << WAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req_valid = 1'b0, req_write = 1'b0, req_full = 1'b0;
  logic [AW-1:0]  req_addr = '0;
  logic [7:0]     req_byte = '0;
  logic [DW-1:0]  req_word = '0;
  logic           req_ready, rsp_valid, mem_rd, mem_wr;
  logic [7:0]     rsp_byte;
  logic [WAW-1:0] mem_addr;
  logic [DW-1:0]  mem_wdata;
  logic [DW-1:0]  mem_rdata = '0;

  always #10 clk = ~clk;

  byte_rmw_adapter #(.ADDR_W(AW), .DATA_W(DW)) u_byte_rmw_adapter (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_full_i(req_full),
    .req_addr_i(req_addr), .req_byte_i(req_byte), .req_word_i(req_word),
    .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  logic [DW-1:0] dut_mem [NW];
  logic [DW-1:0] ref_mem [NW];

  function automatic logic [DW-1:0] init_word(int i);
    return {8'(i), 8'(~i), 8'(i * 3), 8'hA5, 8'(i + 17), 8'h3C, 8'(i * 7), 8'h96};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= dut_mem[mem_addr];
    if (mem_wr) dut_mem[mem_addr] <= mem_wdata;
  end

  typedef struct packed {
    logic           rd, wr, rsp, chk_byte;
    logic [WAW-1:0] addr;
    logic [DW-1:0]  wdata;
    logic [7:0]     rbyte;
  } exp_t;

  exp_t  eq[$];
  string tq[$];
  int    checks = 0, errors = 0;
  bit    cur_idle = 1'b1;
  bit    done = 1'b0;

  task automatic push(exp_t e, string t);
    eq.push_back(e);
    tq.push_back(t);
  endtask

  // one clock: compare outputs with the model's expectation for this cycle
  task automatic step();
    exp_t  e;
    string t;
    logic [DW+WAW+11:0] act, exv;
    @(negedge clk);
    if (eq.size() == 0) begin
      e = '0; t = "R1 R8 R9 idle"; cur_idle = 1'b1;
    end else begin
      e = eq.pop_front(); t = tq.pop_front(); cur_idle = 1'b0;
    end
    act = {req_ready, mem_rd, mem_wr, rsp_valid,
           (mem_rd || mem_wr) ? mem_addr : '0,
           mem_wr ? mem_wdata : '0,
           (rsp_valid && e.chk_byte) ? rsp_byte : 8'h00};
    exv = {cur_idle, e.rd, e.wr, e.rsp,
           (e.rd || e.wr) ? e.addr : '0,
           e.wr ? e.wdata : '0,
           (e.rsp && e.chk_byte) ? e.rbyte : 8'h00};
    checks++;
    if (act !== exv) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", t, $time, act, exv);
    end
  endtask

  // kind: 0 byte read, 1 byte write, 2 full word write
  task automatic run_op(int kind, logic [AW-1:0] a, logic [7:0] b, logic [DW-1:0] w, bit junk);
    exp_t e;
    int   wi, off;
    logic [DW-1:0] old, nw;
    while (!cur_idle) step();
    wi = int'(a >> 3); off = int'(a & 8'h7);
    old = ref_mem[wi];
    req_valid = 1'b1; req_addr = a; req_byte = b; req_word = w;
    req_write = (kind != 0); req_full = (kind == 2);
    if (kind == 1) begin
      nw = old; nw[off*8 +: 8] = b; ref_mem[wi] = nw;
      e = '0; e.rd = 1; e.addr = WAW'(wi);              push(e, "R2 R3 write read phase");
      e = '0;                                           push(e, "R3 merge phase");
      e = '0; e.wr = 1; e.addr = WAW'(wi); e.wdata = nw; push(e, "R3 R4 R5 write-back");
      e = '0; e.rsp = 1; e.chk_byte = 1; e.rbyte = b;   push(e, "R4 R8 write response");
    end else if (kind == 0) begin
      e = '0; e.rd = 1; e.addr = WAW'(wi);              push(e, "R2 R6 read strobe");
      e = '0;                                           push(e, "R6 read wait");
      e = '0; e.rsp = 1; e.chk_byte = 1; e.rbyte = old[off*8 +: 8]; push(e, "R5 R6 R8 read response");
    end else begin
      ref_mem[wi] = w;
      e = '0; e.wr = 1; e.addr = WAW'(wi); e.wdata = w;  push(e, "R7 direct write");
      e = '0; e.rsp = 1; e.chk_byte = 1; e.rbyte = w[7:0]; push(e, "R7 R8 full response");
    end
    step();
    if (junk) begin
      // R9: busy-time request with different content must be ignored
      req_valid = 1'b1; req_write = 1'b1; req_full = 1'b1;
      req_addr = AW'($urandom); req_word = {$urandom, $urandom};
    end else begin
      req_valid = 1'b0;
    end
    while (!cur_idle) step();
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      dut_mem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if ({req_ready, mem_rd, mem_wr, rsp_valid} !== 4'b1000) begin
      errors++;
      $display("FAIL R1 reset actual=%b expected=1000", {req_ready, mem_rd, mem_wr, rsp_valid});
    end
    rst_n = 1'b1;
    step(); step();

    // R5: every lane of one word written then read back
    for (int k = 0; k < 8; k++) run_op(1, AW'(40 + k), 8'(8'h10 + k), '0, 1'b0);
    for (int k = 0; k < 8; k++) run_op(0, AW'(40 + k), '0, '0, 1'b0);
    // R7: full write with nonzero low bits, then lane readback for R5
    run_op(2, AW'(8'h13), '0, 64'h0706050403020100, 1'b0);
    for (int k = 0; k < 8; k++) run_op(0, AW'(8'h10 + k), '0, '0, 1'b0);
    // R4: two merges stacked on the same word
    run_op(1, AW'(8'h12), 8'hEE, '0, 1'b0);
    run_op(1, AW'(8'h17), 8'h77, '0, 1'b0);
    run_op(0, AW'(8'h16), '0, '0, 1'b0);
    // R9: junk held high while busy, for each kind
    run_op(1, AW'(8'h21), 8'h5A, '0, 1'b1);
    run_op(0, AW'(8'h21), '0, '0, 1'b1);
    run_op(2, AW'(8'hF8), '0, 64'hDEADBEEF_CAFEF00D, 1'b1);
    run_op(0, AW'(8'hFF), '0, '0, 1'b1);
    // mixed random traffic, back to back
    for (int n = 0; n < 150; n++)
      run_op(int'($urandom_range(0, 2)), AW'($urandom), 8'($urandom),
             {$urandom, $urandom}, 1'($urandom));
    step(); step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule